// File: doc/BRIEF.md
# Thread Context Ring Matcher

This block decides whether an incoming notification target is currently dispatched on one hardware thread, and if so in which privilege ring. The target arrives as a format bit, a block number, an index, an ignore flag and a logical server number. The thread's interrupt context arrives as three status words, one each for the hypervisor-pool ring, the OS ring and the user ring. Each word is held in big-endian byte order.

The block builds a CAM line from the block number and the index. It byte-swaps the three context words and extracts their valid bits and fields. It then resolves the match in a fixed priority order. A request strobe captures the inputs. On the same clock edge the verdict is registered together with a one-cycle response pulse. A presenter scanning many threads can place one instance per thread and look for a single hit.

Top module: `ctx_ring_matcher`

## Requirements
- R1: The CAM line is the block number shifted left by 19 bit positions, ORed with the 19-bit index. With the default 4-bit block it is 23 bits wide.
- R2: Each context word is taken as big-endian. The block swaps its bytes, so bus bits [7:0] become bits [31:24] of the host-order word. All later fields refer to the host-order word.
- R3: With format 0 and the ignore flag set (logical server mode), the result is hit=0, ring=0 and unsupported=1.
- R4: With format 0 and ignore clear, the pool ring matches when host bit 31 of the pool word is 1 and host bits [22:0] equal the CAM line. The result is then hit=1 and ring=2, whatever the OS word holds.
- R5: With format 0 and ignore clear, and no pool match, the OS ring matches when host bit 31 of the OS word is 1 and its bits [22:0] equal the CAM line. The result is then hit=1 and ring=1.
- R6: With format 1, only the user ring can match, and the ignore flag and the pool word have no effect. Four conditions must all hold: OS bit 31 is 1, OS bits [22:0] equal the CAM line, user bit 31 is 1, and user bits [15:0] equal the logical server number. The result is then hit=1 and ring=0.
- R7: When no rule above matches, the result is hit=0, ring=0 and unsupported=0.
- R8: A result is registered on the rising edge at which the request strobe is high. The response-valid output is high for exactly the cycle after that edge. Without a request, hit, ring and unsupported keep their values.
- R9: While reset is low, every output is 0.
- R10: Host bits [30:23] of the pool and OS words, and host bits [30:16] of the user word, do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| req_i | input | 1 | Request strobe; captures all target and context inputs |
| fmt_i | input | 1 | Notification format (0 specific target, 1 user-level) |
| ignore_i | input | 1 | Low-bit ignore flag (logical server mode when format is 0) |
| blk_i | input | BLK_W | Target block number |
| idx_i | input | IDX_W | Target index |
| lsrv_i | input | LS_W | Logical server number |
| pool_word_i | input | 8*WORD_BYTES | Hypervisor-pool ring status word, big-endian |
| os_word_i | input | 8*WORD_BYTES | OS ring status word, big-endian |
| user_word_i | input | 8*WORD_BYTES | User ring status word, big-endian |
| rsp_valid_o | output | 1 | One-cycle pulse after a captured request |
| hit_o | output | 1 | A ring hosts the target |
| ring_o | output | 2 | Ring code: 0 user, 1 OS, 2 pool |
| unsup_o | output | 1 | Request used the unsupported logical server mode |

## Verification
Every result is due one edge after the request. The rising edge that sees the request high also loads the verdict, so the outputs carry it through the following cycle. The bench applies each request on a falling edge and drops it on the next falling edge. It then reads the result there, half a period after the loading edge. A second falling edge later, it confirms that the response pulse has ended and that the verdict holds while the inputs change. The checker ties each response pulse to a request exactly one edge earlier.

// File: rtl/ctx_ring_pkg.sv
package ctx_ring_pkg;

    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2
    } ring_e;

    typedef struct packed {
        logic  rsp;
        logic  hit;
        ring_e ring;
        logic  unsup;
    } verdict_t;

endpackage

// File: rtl/ctx_word_unpack.sv
module ctx_word_unpack #(
    parameter int WORD_BYTES = 4,
    parameter int FIELD_W    = 23,
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic [WORD_W-1:0]  be_word_i,
    output logic               valid_o,
    output logic [FIELD_W-1:0] field_o
);

    logic [WORD_W-1:0] host_word;

    // reverse the byte lanes: bus byte k lands in host byte WORD_BYTES-1-k
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
        assign host_word[8*(WORD_BYTES-1-b) +: 8] = be_word_i[8*b +: 8];
    end

    assign valid_o = host_word[WORD_W-1];
    assign field_o = host_word[FIELD_W-1:0];

endmodule

// File: rtl/ctx_ring_select.sv
module ctx_ring_select
    import ctx_ring_pkg::*;
#(
    parameter int CAM_W = 23,
    parameter int LS_W  = 16
) (
    input  logic             fmt_i,
    input  logic             ignore_i,
    input  logic [CAM_W-1:0] cam_i,
    input  logic [LS_W-1:0]  lsrv_i,
    input  logic             pool_v_i,
    input  logic [CAM_W-1:0] pool_cam_i,
    input  logic             os_v_i,
    input  logic [CAM_W-1:0] os_cam_i,
    input  logic             usr_v_i,
    input  logic [LS_W-1:0]  usr_ls_i,
    output logic             hit_o,
    output ring_e            ring_o,
    output logic             unsup_o
);

    logic pool_eq;
    logic os_eq;
    logic usr_eq;

    assign pool_eq = pool_v_i && (pool_cam_i == cam_i);
    assign os_eq   = os_v_i && (os_cam_i == cam_i);
    assign usr_eq  = usr_v_i && (usr_ls_i == lsrv_i);

    always_comb begin
        hit_o   = 1'b0;
        ring_o  = RING_USER;
        unsup_o = 1'b0;
        if (!fmt_i) begin
            if (ignore_i) begin
                unsup_o = 1'b1;
            end else if (pool_eq) begin
                hit_o  = 1'b1;
                ring_o = RING_POOL;
            end else if (os_eq) begin
                hit_o  = 1'b1;
                ring_o = RING_OS;
            end
        end else if (os_eq && usr_eq) begin
            hit_o  = 1'b1;
            ring_o = RING_USER;
        end
    end

endmodule

// File: rtl/ctx_ring_matcher.sv
module ctx_ring_matcher
    import ctx_ring_pkg::*;
#(
    parameter int BLK_W      = 4,
    parameter int IDX_W      = 19,
    parameter int LS_W       = 16,
    parameter int WORD_BYTES = 4,
    localparam int WORD_W    = 8 * WORD_BYTES,
    localparam int CAM_W     = BLK_W + IDX_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              fmt_i,
    input  logic              ignore_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LS_W-1:0]   lsrv_i,
    input  logic [WORD_W-1:0] pool_word_i,
    input  logic [WORD_W-1:0] os_word_i,
    input  logic [WORD_W-1:0] user_word_i,
    output logic              rsp_valid_o,
    output logic              hit_o,
    output logic [1:0]        ring_o,
    output logic              unsup_o
);

    logic [CAM_W-1:0] cam_line;
    logic             pool_v, os_v, usr_v;
    logic [CAM_W-1:0] pool_cam, os_cam;
    logic [LS_W-1:0]  usr_ls;
    logic             sel_hit, sel_unsup;
    ring_e            sel_ring;
    verdict_t         st_d, st_q;

    // block number sits above the index bits
    assign cam_line = {blk_i, {IDX_W{1'b0}}} | {{BLK_W{1'b0}}, idx_i};

    ctx_word_unpack #(.WORD_BYTES(WORD_BYTES), .FIELD_W(CAM_W)) u_pool (
        .be_word_i (pool_word_i),
        .valid_o   (pool_v),
        .field_o   (pool_cam)
    );

    ctx_word_unpack #(.WORD_BYTES(WORD_BYTES), .FIELD_W(CAM_W)) u_os (
        .be_word_i (os_word_i),
        .valid_o   (os_v),
        .field_o   (os_cam)
    );

    ctx_word_unpack #(.WORD_BYTES(WORD_BYTES), .FIELD_W(LS_W)) u_user (
        .be_word_i (user_word_i),
        .valid_o   (usr_v),
        .field_o   (usr_ls)
    );

    ctx_ring_select #(.CAM_W(CAM_W), .LS_W(LS_W)) u_sel (
        .fmt_i      (fmt_i),
        .ignore_i   (ignore_i),
        .cam_i      (cam_line),
        .lsrv_i     (lsrv_i),
        .pool_v_i   (pool_v),
        .pool_cam_i (pool_cam),
        .os_v_i     (os_v),
        .os_cam_i   (os_cam),
        .usr_v_i    (usr_v),
        .usr_ls_i   (usr_ls),
        .hit_o      (sel_hit),
        .ring_o     (sel_ring),
        .unsup_o    (sel_unsup)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rsp = 1'b0;
        if (req_i) begin
            st_d.rsp   = 1'b1;
            st_d.hit   = sel_hit;
            st_d.ring  = sel_ring;
            st_d.unsup = sel_unsup;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{rsp: 1'b0, hit: 1'b0, ring: RING_USER, unsup: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp;
    assign hit_o       = st_q.hit;
    assign ring_o      = st_q.ring;
    assign unsup_o     = st_q.unsup;

endmodule

// File: rtl/ctx_ring_matcher_chk.sv
module ctx_ring_matcher_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_i,
    input logic       fmt_i,
    input logic       ignore_i,
    input logic       rsp_valid_o,
    input logic       hit_o,
    input logic [1:0] ring_o,
    input logic       unsup_o
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> rsp_valid_o); // R8

    AST_RSP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $past(req_i)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> ($stable(hit_o) && $stable(ring_o) && $stable(unsup_o))); // R8

    AST_LS_MODE_UNSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !fmt_i && ignore_i) |=> (unsup_o && !hit_o)); // R3

    AST_UNSUP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unsup_o |-> (!hit_o && ring_o == 2'd0)); // R3

    AST_USER_ONLY_FMT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && fmt_i) |=> (!hit_o || ring_o == 2'd0)); // R6

    AST_FMT0_NOT_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !fmt_i) |=> (!hit_o || ring_o == 2'd1 || ring_o == 2'd2)); // R4

    AST_MISS_RING_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> ring_o == 2'd0); // R7

endmodule

bind ctx_ring_matcher ctx_ring_matcher_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .fmt_i       (fmt_i),
    .ignore_i    (ignore_i),
    .rsp_valid_o (rsp_valid_o),
    .hit_o       (hit_o),
    .ring_o      (ring_o),
    .unsup_o     (unsup_o)
);

// File: tb/ctx_ring_matcher_tb.sv
`timescale 1ns/1ps
module ctx_ring_matcher_tb;

    typedef struct packed {
        logic [3:0]  tag;
        logic        fmt;
        logic        ign;
        logic [3:0]  blk;
        logic [18:0] idx;
        logic [15:0] ls;
        logic [31:0] pool;   // host order
        logic [31:0] os;     // host order
        logic [31:0] usr;    // host order
        logic        hit;
        logic [1:0]  ring;
        logic        unsup;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{4'd4,  1'b0, 1'b0, 4'd3, 19'h12345, 16'h0000, 32'h80192345, 32'h80192345, 32'h00000000, 1'b1, 2'd2, 1'b0}, // R4 pool beats OS
        '{4'd5,  1'b0, 1'b0, 4'd3, 19'h12345, 16'h0000, 32'h00192345, 32'h80192345, 32'h00000000, 1'b1, 2'd1, 1'b0}, // R5 pool invalid
        '{4'd5,  1'b0, 1'b0, 4'd3, 19'h12345, 16'h0000, 32'h80192346, 32'h80192345, 32'h00000000, 1'b1, 2'd1, 1'b0}, // R5 pool cam differs
        '{4'd7,  1'b0, 1'b0, 4'd3, 19'h12345, 16'h0000, 32'h00000000, 32'h00192345, 32'h00000000, 1'b0, 2'd0, 1'b0}, // R7 nothing valid
        '{4'd3,  1'b0, 1'b1, 4'd3, 19'h12345, 16'h0000, 32'h80192345, 32'h80192345, 32'h00000000, 1'b0, 2'd0, 1'b1}, // R3
        '{4'd6,  1'b1, 1'b0, 4'd3, 19'h12345, 16'h00AB, 32'h80192345, 32'h80192345, 32'h800000AB, 1'b1, 2'd0, 1'b0}, // R6 user hit
        '{4'd6,  1'b1, 1'b0, 4'd3, 19'h12345, 16'h00AB, 32'h80192345, 32'h80192345, 32'h800000AC, 1'b0, 2'd0, 1'b0}, // R6 server differs
        '{4'd6,  1'b1, 1'b0, 4'd3, 19'h12345, 16'h00AB, 32'h80192345, 32'h80192345, 32'h000000AB, 1'b0, 2'd0, 1'b0}, // R6 user invalid
        '{4'd6,  1'b1, 1'b0, 4'd3, 19'h12345, 16'h00AB, 32'h80192345, 32'h00192345, 32'h800000AB, 1'b0, 2'd0, 1'b0}, // R6 OS invalid
        '{4'd6,  1'b1, 1'b1, 4'd3, 19'h12345, 16'h00AB, 32'h00000000, 32'h80192345, 32'h800000AB, 1'b1, 2'd0, 1'b0}, // R6 ignore no effect
        '{4'd6,  1'b1, 1'b0, 4'd3, 19'h12345, 16'h00AB, 32'h80192345, 32'h00000000, 32'h800000AB, 1'b0, 2'd0, 1'b0}, // R6 pool no effect
        '{4'd1,  1'b0, 1'b0, 4'd1, 19'h00000, 16'h0000, 32'h00000000, 32'h80080000, 32'h00000000, 1'b1, 2'd1, 1'b0}, // R1 block only
        '{4'd1,  1'b0, 1'b0, 4'hF, 19'h7FFFF, 16'h0000, 32'h807FFFFF, 32'h00000000, 32'h00000000, 1'b1, 2'd2, 1'b0}, // R1 all ones
        '{4'd10, 1'b0, 1'b0, 4'd3, 19'h12345, 16'h0000, 32'hFF992345, 32'h00000000, 32'h00000000, 1'b1, 2'd2, 1'b0}, // R10 pool spare bits
        '{4'd10, 1'b1, 1'b0, 4'd3, 19'h12345, 16'h00AB, 32'h00000000, 32'hFF992345, 32'hFFFF00AB, 1'b1, 2'd0, 1'b0}, // R10 OS/user spare bits
        '{4'd2,  1'b0, 1'b0, 4'd3, 19'h12345, 16'h0000, 32'h45231980, 32'h80192345, 32'h00000000, 1'b1, 2'd1, 1'b0}  // R2 pool word given in wrong byte order
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_i = 1'b0;
    logic        fmt_i = 1'b0;
    logic        ignore_i = 1'b0;
    logic [3:0]  blk_i = '0;
    logic [18:0] idx_i = '0;
    logic [15:0] lsrv_i = '0;
    logic [31:0] pool_word_i = '0;
    logic [31:0] os_word_i = '0;
    logic [31:0] user_word_i = '0;
    logic        rsp_valid_o;
    logic        hit_o;
    logic [1:0]  ring_o;
    logic        unsup_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    ctx_ring_matcher u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (req_i),
        .fmt_i       (fmt_i),
        .ignore_i    (ignore_i),
        .blk_i       (blk_i),
        .idx_i       (idx_i),
        .lsrv_i      (lsrv_i),
        .pool_word_i (pool_word_i),
        .os_word_i   (os_word_i),
        .user_word_i (user_word_i),
        .rsp_valid_o (rsp_valid_o),
        .hit_o       (hit_o),
        .ring_o      (ring_o),
        .unsup_o     (unsup_o)
    );

    function automatic logic [31:0] to_bus(input logic [31:0] h);
        return {h[7:0], h[15:8], h[23:16], h[31:24]};
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {rsp,hit,ring,unsup} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk_i);
        fmt_i       = v.fmt;
        ignore_i    = v.ign;
        blk_i       = v.blk;
        idx_i       = v.idx;
        lsrv_i      = v.ls;
        pool_word_i = to_bus(v.pool);
        os_word_i   = to_bus(v.os);
        user_word_i = to_bus(v.usr);
        req_i       = 1'b1;
        @(negedge clk_i);
        req_i       = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk_i);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9 reset state, with a request pending during reset
        req_i = 1'b1;
        repeat (3) @(negedge clk_i);
        check("R9", {rsp_valid_o, hit_o, ring_o, unsup_o}, 5'b0_0_00_0);
        req_i = 1'b0;
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R9", {rsp_valid_o, hit_o, ring_o, unsup_o}, 5'b0_0_00_0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("R%0d vec%0d", VEC[i].tag, i),
                  {rsp_valid_o, hit_o, ring_o, unsup_o},
                  {1'b1, VEC[i].hit, VEC[i].ring, VEC[i].unsup});
        end

        // R8: pulse ends, verdict holds while inputs change without a request
        apply(VEC[0]);
        check("R8 pulse", {rsp_valid_o, hit_o, ring_o, unsup_o}, 5'b1_1_10_0);
        pool_word_i = 32'h0;
        os_word_i   = 32'h0;
        ignore_i    = 1'b1;
        @(negedge clk_i);
        check("R8 hold", {rsp_valid_o, hit_o, ring_o, unsup_o}, 5'b0_1_10_0);
        @(negedge clk_i);
        check("R8 hold2", {rsp_valid_o, hit_o, ring_o, unsup_o}, 5'b0_1_10_0);

        // R8: back-to-back requests each produce their own verdict
        @(negedge clk_i);
        fmt_i = 1'b0; ignore_i = 1'b1; req_i = 1'b1;
        @(negedge clk_i);
        check("R8 b2b first R3", {rsp_valid_o, hit_o, ring_o, unsup_o}, 5'b1_0_00_1);
        ignore_i = 1'b0; os_word_i = to_bus(32'h80192345); blk_i = 4'd3; idx_i = 19'h12345;
        @(negedge clk_i);
        req_i = 1'b0;
        check("R8 b2b second R5", {rsp_valid_o, hit_o, ring_o, unsup_o}, 5'b1_1_01_0);

        // R9: reset clears a held hit
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R9 mid-run", {rsp_valid_o, hit_o, ring_o, unsup_o}, 5'b0_0_00_0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule